// File: doc/BRIEF.md
# Differential Two-Leg PWM Set-Point Generator

This block turns a signed analog set-point into two unipolar pulse-width outputs. One output serves the positive leg and the other the negative leg. Each leg is smoothed outside the chip by its own RC low-pass filter, and the analog set-point is the difference between the two filtered voltages. That difference spans roughly -3.3 V to +3.3 V. To produce a positive set-point, software programs the magnitude into the positive-leg duty register and zero into the negative one. For a negative set-point it does the reverse.

Duty writes from a simple 32-bit register bus land in staging (shadow) registers and do not affect the outputs. A write to a separate commit register arms a transfer. At the last count of the current PWM period, both shadow values move into the active registers together, so the two legs always switch at the same period boundary and no period is cut short. Both legs compare a single shared free-running period counter against their own active duty.

Top module: `diffpwm_setpoint`

## Requirements
- R1: After reset, both shadow duties and both active duties are zero. Both PWM outputs stay low, and reads of offsets 0x0 and 0x4 return 0.
- R2: A bus write to offset 0x0 stores bits [DUTY_W-1:0] of the write data as the positive-leg shadow duty. A write to 0x4 does the same for the negative leg. Reads of those offsets return the shadow value, zero-extended to 32 bits.
- R3: A shadow write that is not followed by a commit leaves both PWM outputs unchanged.
- R4: A write of any data to offset 0x8 arms a commit. Both active duties are loaded from the shadows on the clock edge at which the period counter wraps from its maximum to 0. The new duties therefore govern the whole of the next period.
- R5: The period counter advances by one on every clock and wraps from 2^DUTY_W-1 to 0. A period is 2^DUTY_W clocks long.
- R6: A leg's output is high exactly while the counter is below that leg's active duty. A duty of 0 gives a constant low output. A duty of 2^DUTY_W-1 gives a high output for all counts of a period except one.
- R7: When both legs hold nonzero duties, each leg is driven as programmed and independently of the other.
- R8: A commit written in the cycle in which the counter sits at its maximum takes effect at that same wrap.
- R9: If a shadow write falls on the same edge as a commit load, the active register receives the shadow value held before that write. The new value waits for a later commit.
- R10: Reads of offset 0x8 and of unmapped offsets return 0. Several commits before one wrap give a single load at that wrap, and no further load at the following wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| pwm_pos | output | 1 | Positive-leg PWM output |
| pwm_neg | output | 1 | Negative-leg PWM output |

## Verification
Two functions can fall on the same clock edge: the period-end transfer from shadow to active registers, and a bus access.

The bench provokes this in two ways. It places a commit write exactly in the cycle where the counter sits at its maximum. It also places a duty write on the edge where an earlier commit is being applied.

A behavioural model judges both cases. The model updates its active copies from the shadow contents held before the write, and only then applies the write. It is compared against both outputs and the read data on every cycle. Both legs are also run nonzero together, and across the zero and full-scale duties.

// File: rtl/diffpwm_pkg.sv
package diffpwm_pkg;

  typedef enum logic [1:0] {
    SEL_POS  = 2'd0,
    SEL_NEG  = 2'd1,
    SEL_GO   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Byte offsets of the registers
  localparam int unsigned OFS_POS = 0;
  localparam int unsigned OFS_NEG = 4;
  localparam int unsigned OFS_GO  = 8;

  function automatic reg_sel_e decode_offset(input int unsigned ofs);
    case (ofs)
      OFS_POS: return SEL_POS;
      OFS_NEG: return SEL_NEG;
      OFS_GO:  return SEL_GO;
      default: return SEL_NONE;
    endcase
  endfunction

  // Output level of one leg: high while the count is below the duty
  function automatic logic leg_level(input int unsigned count, input int unsigned duty);
    return count < duty;
  endfunction

endpackage

// File: rtl/diffpwm_period.sv
module diffpwm_period #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt,
  output logic         period_end
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign period_end = (cnt == CNT_MAX);
endmodule

// File: rtl/diffpwm_leg.sv
module diffpwm_leg #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty,
  output logic         pwm
);
  import diffpwm_pkg::*;

  assign pwm = leg_level(int'(cnt), int'(duty));
endmodule

// File: rtl/diffpwm_regs.sv
module diffpwm_regs #(
  parameter int DUTY_W = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic                   period_end,
  output logic [1:0][DUTY_W-1:0] act_duty,
  output logic                   commit_wr,
  output logic                   load_evt,
  output logic                   commit_pend
);
  import diffpwm_pkg::*;

  localparam int LEGS = 2;

  logic [1:0][DUTY_W-1:0] shd_duty;
  reg_sel_e               sel;

  assign sel       = decode_offset(int'(bus_addr));
  assign commit_wr = bus_sel && bus_we && (sel == SEL_GO);
  assign load_evt  = period_end && (commit_pend || commit_wr);

  // Shadow registers, one per leg
  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    localparam reg_sel_e MY_SEL = (g == 0) ? SEL_POS : SEL_NEG;

    always_ff @(posedge clk) begin
      if (!rst_n)
        shd_duty[g] <= '0;
      else if (bus_sel && bus_we && (sel == MY_SEL))
        shd_duty[g] <= bus_wdata[DUTY_W-1:0];
    end

    // Active register takes the shadow contents held before this edge
    always_ff @(posedge clk) begin
      if (!rst_n)        act_duty[g] <= '0;
      else if (load_evt) act_duty[g] <= shd_duty[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         commit_pend <= 1'b0;
    else if (load_evt)  commit_pend <= 1'b0;
    else if (commit_wr) commit_pend <= 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_POS: bus_rdata = DATA_W'(shd_duty[0]);
      SEL_NEG: bus_rdata = DATA_W'(shd_duty[1]);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/diffpwm_setpoint.sv
module diffpwm_setpoint #(
  parameter int DUTY_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_pos,
  output logic              pwm_neg
);
  localparam int LEGS = 2;

  logic [DUTY_W-1:0]           cnt;
  logic                        period_end;
  logic [1:0][DUTY_W-1:0]      act_duty;
  logic                        commit_wr;
  logic                        load_evt;
  logic                        commit_pend;
  logic [LEGS-1:0]             pwm_leg;

  diffpwm_period #(.W(DUTY_W)) u_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt),
    .period_end (period_end)
  );

  diffpwm_regs #(.DUTY_W(DUTY_W), .ADDR_W(ADDR_W), .DATA_W(32)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .period_end  (period_end),
    .act_duty    (act_duty),
    .commit_wr   (commit_wr),
    .load_evt    (load_evt),
    .commit_pend (commit_pend)
  );

  for (genvar g = 0; g < LEGS; g++) begin : g_cmp
    diffpwm_leg #(.W(DUTY_W)) u_leg (
      .cnt  (cnt),
      .duty (act_duty[g]),
      .pwm  (pwm_leg[g])
    );
  end

  assign pwm_pos = pwm_leg[0];
  assign pwm_neg = pwm_leg[1];
endmodule

// File: rtl/diffpwm_setpoint_chk.sv
module diffpwm_setpoint_chk #(
  parameter int W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [W-1:0]       cnt,
  input logic               period_end,
  input logic               load_evt,
  input logic               commit_pend,
  input logic [1:0][W-1:0]  act_duty,
  input logic               pwm_pos,
  input logic               pwm_neg
);
  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt == W'($past(cnt) + 1'b1));

  // R4
  load_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> period_end);

  // R4
  armed_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pend && period_end) |-> load_evt);

  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(act_duty));

  // R10
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !commit_pend);

  // R6
  zero_pos_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_duty[0] == '0) |-> !pwm_pos);

  // R6
  zero_neg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_duty[1] == '0) |-> !pwm_neg);

  // R7
  start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (pwm_pos == (act_duty[0] != '0)) && (pwm_neg == (act_duty[1] != '0)));
endmodule

bind diffpwm_setpoint diffpwm_setpoint_chk #(.W(DUTY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt         (cnt),
  .period_end  (period_end),
  .load_evt    (load_evt),
  .commit_pend (commit_pend),
  .act_duty    (act_duty),
  .pwm_pos     (pwm_pos),
  .pwm_neg     (pwm_neg)
);

// File: tb/diffpwm_setpoint_test.sv
module diffpwm_setpoint_test;
  localparam int W    = 8;
  localparam int AW   = 4;
  localparam int MAXC = (1 << W) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          pwm_pos, pwm_neg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt = 0;
  int m_shd[2] = '{0, 0};
  int m_act[2] = '{0, 0};
  bit m_pend = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  diffpwm_setpoint #(.DUTY_W(W), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_pos(pwm_pos), .pwm_neg(pwm_neg)
  );

  // Behavioural model: load from old shadow first, then apply the bus write
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_shd = '{0, 0}; m_act = '{0, 0}; m_pend = 1'b0;
    end else begin
      bit go;
      go = bus_sel && bus_we && (bus_addr == 4'h8);
      if (m_cnt == MAXC && (m_pend || go)) begin
        m_act[0] = m_shd[0]; m_act[1] = m_shd[1]; m_pend = 1'b0;
      end else if (go) m_pend = 1'b1;
      if (bus_sel && bus_we && bus_addr == 4'h0) m_shd[0] = int'(bus_wdata[W-1:0]);
      if (bus_sel && bus_we && bus_addr == 4'h4) m_shd[1] = int'(bus_wdata[W-1:0]);
      m_cnt = (m_cnt + 1) % (MAXC + 1);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int er;
      check("R6 pwm_pos", int'(pwm_pos), int'(m_cnt < m_act[0]));
      check("R7 pwm_neg", int'(pwm_neg), int'(m_cnt < m_act[1]));
      if (bus_sel && !bus_we) begin
        er = (bus_addr == 4'h0) ? m_shd[0] : (bus_addr == 4'h4) ? m_shd[1] : 0;
        check("R2 rdata", int'(bus_rdata), er);
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wait_cnt(input int v);
    do step(); while (m_cnt != v);
  endtask

  // drive a write now; it is taken at the next edge
  task automatic drive_write(input logic [AW-1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic read_check(input logic [AW-1:0] a, input int exp, input string tag);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    check(tag, int'(bus_rdata), exp);
    step();
    bus_sel = 1'b0;
  endtask

  // count high cycles of each leg over one full period starting at count 0
  task automatic count_period(output int hp, output int hn);
    hp = 0; hn = 0;
    wait_cnt(0);
    for (int i = 0; i <= MAXC; i++) begin
      @(negedge clk);
      hp += int'(pwm_pos); hn += int'(pwm_neg);
      step();
    end
  endtask

  initial begin
    int hp, hn;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 pos low", int'(pwm_pos), 0);
    check("R1 neg low", int'(pwm_neg), 0);
    step();
    read_check(4'h0, 0, "R1 readback pos");
    read_check(4'h4, 0, "R1 readback neg");

    // R2: shadow write and readback, upper bits dropped
    drive_write(4'h0, 32'h0000_1264);
    drive_write(4'h4, 32'h0);
    read_check(4'h0, 'h64, "R2 readback pos");
    read_check(4'h4, 0, "R2 readback neg");

    // R3: no commit -> outputs stay low over a whole period
    count_period(hp, hn);
    check("R3 pos uncommitted", hp, 0);
    check("R3 neg uncommitted", hn, 0);

    // R4: commit mid-period, applies at wrap
    wait_cnt(20);
    drive_write(4'h8, 32'hA5);
    @(negedge clk);
    check("R4 not before wrap", int'(pwm_pos), 0);
    count_period(hp, hn);
    check("R4 pos high count", hp, 'h64);
    check("R4 neg high count", hn, 0);

    // R7 and R10: both nonzero, double commit gives a single load
    drive_write(4'h0, 32'd30);
    drive_write(4'h4, 32'd200);
    drive_write(4'h8, 32'h0);
    drive_write(4'h8, 32'h1);
    count_period(hp, hn);
    check("R7 pos both nonzero", hp, 30);
    check("R7 neg both nonzero", hn, 200);
    drive_write(4'h0, 32'd5);   // no new commit
    count_period(hp, hn);
    check("R10 no second load", hp, 30);

    // R6: full scale and zero
    drive_write(4'h0, MAXC);
    drive_write(4'h4, 32'd0);
    drive_write(4'h8, 32'h0);
    count_period(hp, hn);
    check("R6 full scale", hp, MAXC);
    check("R6 zero duty", hn, 0);

    // R8: commit in the cycle the counter sits at its maximum
    drive_write(4'h4, 32'd77);
    wait_cnt(MAXC);
    drive_write(4'h8, 32'h0);
    // now counter at 0 of the new period
    @(negedge clk);
    check("R8 neg at wrap", int'(pwm_neg), 1);
    count_period(hp, hn);
    check("R8 neg count", hn, 77);

    // R9: duty write lands on the load edge
    drive_write(4'h4, 32'd10);
    drive_write(4'h8, 32'h0);
    wait_cnt(MAXC);
    drive_write(4'h4, 32'd150);
    count_period(hp, hn);
    check("R9 old shadow loaded", hn, 10);
    read_check(4'h4, 150, "R9 new shadow kept");

    // R10: reads of commit and unmapped offsets
    read_check(4'h8, 0, "R10 commit read");
    read_check(4'hC, 0, "R10 unmapped read");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule